// File: doc/BRIEF.md
# Voice Envelope Generator

This block shapes the loudness of one synthesizer voice. It holds an 11-bit envelope level that rises and falls over time, and it presents the top 7 bits of that level as the envelope value. Software configures it with three bytes: two envelope-phase bytes and one direct-control byte. It also receives single-cycle key-on and key-off pulses and a sample-tick enable. The level only moves on sample ticks. Key-on and key-off act in the cycle they arrive.

When bit 7 of the first phase byte is set, the block runs a four-phase sequence. The phases are attack (linear rise), decay (exponential fall down to a programmable sustain band), sustain (exponential fall for as long as the key is held) and release (a fixed fall after key-off). When that bit is clear, the direct-control byte selects one of five behaviours:

- set the level outright;
- linear rise;
- two-slope rise;
- linear fall;
- exponential fall.

Every sloped behaviour has a 5-bit rate. A shared counter turns that rate into an update period, measured in sample ticks.

Top module: `env_gen`

## Requirements
- R1: After reset, `env_level` is 0 and `env_phase` is release (code 3). Phase codes are attack=0, decay=1, sustain=2, release=3.
- R2: A `key_on` pulse makes `env_level` 0 and `env_phase` attack in the next cycle. This happens even if `key_off` is asserted in the same cycle.
- R3: A `key_off` pulse without `key_on` moves the phase to release in the next cycle. In release, every tick subtracts 8 from the level, stopping at 0. This applies in both control schemes.
- R4: A 5-bit rate of 0 freezes the level. A rate r>0 applies one step on every P-th tick, where P = 1 << ((31-r)>>1). The tick count restarts from 0 at key-on and at each phase change.
- R5: Phase mode is selected by `adsr_cfg0[7]`=1. The attack rate is A=`adsr_cfg0[3:0]`, and the step rate is 2A+1. Each attack step adds 32. When A=15, the first tick sets the level to 0x7FF. Attack passes to decay on the step that brings the level to 0x7E0 or above.
- R6: Decay uses rate 16+2D, where D=`adsr_cfg0[6:4]`. Each step subtracts ((level-1)>>8)+1. Decay passes to sustain on the step whose result has level[10:8] equal to `adsr_cfg1[7:5]`.
- R7: Sustain applies the same exponential step at rate `adsr_cfg1[4:0]`. It leaves only on key-on or key-off.
- R8: Direct mode is selected by `adsr_cfg0[7]`=0. With `gain_cfg[7]`=0, each tick loads the level with `gain_cfg[6:0]` shifted left by 4.
- R9: `gain_cfg[7:5]`=110 adds 32 per step and `gain_cfg[7:5]`=100 subtracts 32 per step. The level is clamped to 0..0x7FF. The rate is `gain_cfg[4:0]`.
- R10: `gain_cfg[7:5]`=111 adds 32 per step while the level is below 0x600, and 8 per step otherwise. The level is clamped at 0x7FF.
- R11: `gain_cfg[7:5]`=101 subtracts ((level-1)>>8)+1 per step. A level of 0 stays at 0.
- R12: `env_value` always equals `env_level[10:4]`. Without a tick or a key-on, the level does not change, even if the configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-tick enable |
| key_on | input | 1 | Note start pulse |
| key_off | input | 1 | Note release pulse |
| adsr_cfg0 | input | 8 | Phase-mode select, decay rate, attack rate |
| adsr_cfg1 | input | 8 | Sustain band, sustain rate |
| gain_cfg | input | 8 | Direct-control mode and value/rate |
| env_level | output | 11 | Envelope level |
| env_value | output | 7 | Readable 7-bit envelope value |
| env_phase | output | 2 | Current phase code |

## Verification
The hardest case to reach is the hand-off from decay to sustain at a band below the top. This needs a long run of exponential steps whose size changes as the level crosses each 256-wide band. The stimulus first uses an instant attack to pin the level at 0x7FF with a period-1 decay. It then counts ticks to the exact step at which the level drops out of band 7, and checks the value and the phase one step before and on that step. The two-slope knee and the clamps are reached quickly by first loading a chosen level in direct-set mode and then switching the mode byte.

// File: rtl/envgen_pkg.sv
package envgen_pkg;

    localparam int LVL_W  = 11;
    localparam int RATE_W = 5;
    localparam int CNT_W  = 16;
    localparam int VAL_W  = 7;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [CNT_W-1:0]  count_t;

    localparam level_t LVL_MAX   = '1;
    localparam level_t ATK_DONE  = 11'h7E0;
    localparam level_t BENT_KNEE = 11'h600;
    localparam rate_t  RATE_FAST = '1;

    typedef enum logic [1:0] {
        PH_ATTACK  = 2'd0,
        PH_DECAY   = 2'd1,
        PH_SUSTAIN = 2'd2,
        PH_RELEASE = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        SK_HOLD, SK_SET, SK_LIN_UP, SK_LIN_DN,
        SK_BENT_UP, SK_EXP_DN, SK_REL_DN, SK_FULL
    } step_e;

    typedef struct packed {
        step_e  kind;
        rate_t  rate;
        level_t set_val;
    } step_req_t;

    // Number of ticks between updates for a nonzero rate.
    function automatic count_t rate_period(rate_t r);
        return count_t'(1) << ((RATE_FAST - r) >> 1);
    endfunction

    function automatic level_t exp_dec(level_t l);
        level_t dec;
        dec = ((l - level_t'(1)) >> 8) + level_t'(1);
        return (l == '0) ? '0 : l - dec;
    endfunction

endpackage

// File: rtl/env_rate_timer.sv
module env_rate_timer
    import envgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  tick,
    input  rate_t rate,
    output logic  fire
);
    count_t cnt;
    count_t per_m1;

    assign per_m1 = rate_period(rate) - count_t'(1);
    assign fire   = tick && (rate != '0) && (cnt >= per_m1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && rate != '0) begin
            cnt <= (cnt >= per_m1) ? '0 : cnt + count_t'(1);
        end
    end
endmodule

// File: rtl/env_step_calc.sv
module env_step_calc
    import envgen_pkg::*;
(
    input  step_req_t req,
    input  level_t    cur,
    output level_t    nxt
);
    localparam int WIDE = LVL_W + 1;
    logic [WIDE-1:0] up_sum;
    logic [WIDE-1:0] up_amt;

    always_comb begin
        up_amt = (req.kind == SK_BENT_UP && cur >= BENT_KNEE) ? WIDE'(8) : WIDE'(32);
        up_sum = {1'b0, cur} + up_amt;
        case (req.kind)
            SK_SET:     nxt = req.set_val;
            SK_FULL:    nxt = LVL_MAX;
            SK_LIN_UP,
            SK_BENT_UP: nxt = (up_sum > {1'b0, LVL_MAX}) ? LVL_MAX : up_sum[LVL_W-1:0];
            SK_LIN_DN:  nxt = (cur < level_t'(32)) ? '0 : cur - level_t'(32);
            SK_REL_DN:  nxt = (cur < level_t'(8))  ? '0 : cur - level_t'(8);
            SK_EXP_DN:  nxt = exp_dec(cur);
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/env_gen.sv
module env_gen
    import envgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        key_on,
    input  logic        key_off,
    input  logic [7:0]  adsr_cfg0,
    input  logic [7:0]  adsr_cfg1,
    input  logic [7:0]  gain_cfg,
    output logic [10:0] env_level,
    output logic [6:0]  env_value,
    output logic [1:0]  env_phase
);
    phase_e    phase, phase_nxt;
    level_t    level, level_nxt, stepped, after;
    step_req_t req;
    logic      fire, apply, restart, phase_mode;
    logic [2:0] sus_band;

    assign phase_mode = adsr_cfg0[7];
    assign sus_band   = adsr_cfg1[7:5];

    // Select step kind and rate from phase and control bytes.
    always_comb begin
        req = '{kind: SK_HOLD, rate: '0, set_val: '0};
        if (phase == PH_RELEASE) begin
            req.kind = SK_REL_DN;
            req.rate = RATE_FAST;
        end else if (!phase_mode) begin
            req.rate = gain_cfg[4:0];
            if (!gain_cfg[7]) begin
                req.kind    = SK_SET;
                req.rate    = RATE_FAST;
                req.set_val = {gain_cfg[6:0], 4'b0000};
            end else begin
                case (gain_cfg[6:5])
                    2'b00:   req.kind = SK_LIN_DN;
                    2'b01:   req.kind = SK_EXP_DN;
                    2'b10:   req.kind = SK_LIN_UP;
                    default: req.kind = SK_BENT_UP;
                endcase
            end
        end else begin
            case (phase)
                PH_ATTACK: begin
                    req.kind = (adsr_cfg0[3:0] == 4'hF) ? SK_FULL : SK_LIN_UP;
                    req.rate = {adsr_cfg0[3:0], 1'b1};
                end
                PH_DECAY: begin
                    req.kind = SK_EXP_DN;
                    req.rate = {1'b1, adsr_cfg0[6:4], 1'b0};
                end
                default: begin
                    req.kind = SK_EXP_DN;
                    req.rate = adsr_cfg1[4:0];
                end
            endcase
        end
    end

    env_rate_timer u_timer (
        .clk(clk), .rst(rst), .restart(restart),
        .tick(tick), .rate(req.rate), .fire(fire)
    );

    env_step_calc u_step (.req(req), .cur(level), .nxt(stepped));

    assign apply = (req.kind == SK_SET) ? tick : fire;
    assign after = apply ? stepped : level;

    always_comb begin
        phase_nxt = phase;
        if (key_on)
            phase_nxt = PH_ATTACK;
        else if (key_off)
            phase_nxt = PH_RELEASE;
        else if (apply && phase_mode && phase == PH_ATTACK && after >= ATK_DONE)
            phase_nxt = PH_DECAY;
        else if (apply && phase_mode && phase == PH_DECAY && after[LVL_W-1:8] == sus_band)
            phase_nxt = PH_SUSTAIN;
        level_nxt = key_on ? '0 : after;
    end

    assign restart = key_on || (phase_nxt != phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RELEASE;
            level <= '0;
        end else begin
            phase <= phase_nxt;
            level <= level_nxt;
        end
    end

    assign env_level = level;
    assign env_value = level[LVL_W-1 -: VAL_W];
    assign env_phase = phase;
endmodule

// File: rtl/env_gen_chk.sv
module env_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        key_on,
    input logic        key_off,
    input logic [10:0] env_level,
    input logic [1:0]  env_phase
);
    a_r2_keyon_restart: assert property (@(posedge clk) disable iff (rst)
        key_on |=> (env_level == 11'd0 && env_phase == 2'd0));

    a_r3_keyoff_release: assert property (@(posedge clk) disable iff (rst)
        (key_off && !key_on) |=> env_phase == 2'd3);

    a_r3_release_falls: assert property (@(posedge clk) disable iff (rst)
        (env_phase == 2'd3 && !key_on) |=> env_level <= $past(env_level));

    a_r5_attack_exit: assert property (@(posedge clk) disable iff (rst)
        (env_phase == 2'd0 && !key_off) |=> (env_phase == 2'd0 || env_phase == 2'd1));

    a_r6_decay_exit: assert property (@(posedge clk) disable iff (rst)
        (env_phase == 2'd1 && !key_on && !key_off) |=> (env_phase == 2'd1 || env_phase == 2'd2));

    a_r7_sustain_hold: assert property (@(posedge clk) disable iff (rst)
        (env_phase == 2'd2 && !key_on && !key_off) |=> env_phase == 2'd2);

    a_r12_no_tick_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick && !key_on) |=> $stable(env_level));
endmodule

bind env_gen env_gen_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
    .env_level(env_level), .env_phase(env_phase)
);

// File: tb/sim_env_gen.sv
module sim_env_gen;
    logic clk = 1'b0;
    logic rst, tick, key_on, key_off;
    logic [7:0] adsr_cfg0, adsr_cfg1, gain_cfg;
    logic [10:0] env_level;
    logic [6:0]  env_value;
    logic [1:0]  env_phase;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    env_gen u0 (
        .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
        .adsr_cfg0(adsr_cfg0), .adsr_cfg1(adsr_cfg1), .gain_cfg(gain_cfg),
        .env_level(env_level), .env_value(env_value), .env_phase(env_phase)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic kon();
        @(negedge clk) key_on = 1'b1;
        @(negedge clk) key_on = 1'b0;
    endtask

    task automatic kof();
        @(negedge clk) key_off = 1'b1;
        @(negedge clk) key_off = 1'b0;
    endtask

    task automatic load_direct(input logic [6:0] v);
        @(negedge clk);
        adsr_cfg0 = 8'h00;
        gain_cfg  = {1'b0, v};
        kon();
        ticks(1);
    endtask

    task automatic t_reset();
        chk("R1 level", env_level, 0);
        chk("R1 phase", env_phase, 3);
    endtask

    task automatic t_direct();
        load_direct(7'h55);
        chk("R8 level", env_level, 11'h550);
        chk("R12 value", env_value, 7'h55);
        @(negedge clk) gain_cfg = 8'h22;
        repeat (5) @(negedge clk);
        chk("R12 no tick", env_level, 11'h550);
    endtask

    task automatic t_lin_up();
        @(negedge clk) gain_cfg = 8'hDF;
        ticks(3);
        chk("R9 up", env_level, 11'h5B0);
        @(negedge clk) gain_cfg = 8'hC0;
        ticks(4);
        chk("R4 rate0", env_level, 11'h5B0);
        load_direct(7'h7E);
        @(negedge clk) gain_cfg = 8'hDF;
        ticks(2);
        chk("R9 clamp top", env_level, 11'h7FF);
    endtask

    task automatic t_period();
        @(negedge clk) begin adsr_cfg0 = 8'h00; gain_cfg = 8'hDD; end
        kon();
        ticks(1);
        chk("R4 p2 first", env_level, 0);
        ticks(1);
        chk("R4 p2 second", env_level, 32);
        ticks(2);
        chk("R4 p2 fourth", env_level, 64);
    endtask

    task automatic t_lin_dn();
        load_direct(7'h03);
        @(negedge clk) gain_cfg = 8'h9F;
        ticks(1);
        chk("R9 down", env_level, 11'h010);
        ticks(1);
        chk("R9 floor", env_level, 0);
    endtask

    task automatic t_bent();
        load_direct(7'h5F);
        @(negedge clk) gain_cfg = 8'hFF;
        ticks(1);
        chk("R10 below knee", env_level, 11'h610);
        ticks(1);
        chk("R10 above knee", env_level, 11'h618);
        load_direct(7'h7F);
        @(negedge clk) gain_cfg = 8'hFF;
        ticks(2);
        chk("R10 clamp", env_level, 11'h7FF);
    endtask

    task automatic t_exp();
        load_direct(7'h7F);
        @(negedge clk) gain_cfg = 8'hBF;
        ticks(1);
        chk("R11 high", env_level, 11'h7E8);
        load_direct(7'h01);
        @(negedge clk) gain_cfg = 8'hBF;
        ticks(1);
        chk("R11 low", env_level, 11'h00F);
    endtask

    task automatic t_attack();
        @(negedge clk) begin adsr_cfg0 = 8'hFF; adsr_cfg1 = 8'hE0; end
        kon();
        ticks(1);
        chk("R5 instant", env_level, 11'h7FF);
        chk("R5 to decay", env_phase, 1);
        @(negedge clk) adsr_cfg0 = 8'h8E;
        kon();
        ticks(124);
        chk("R5 linear", env_level, 11'h7C0);
        chk("R5 still attack", env_phase, 0);
        ticks(2);
        chk("R5 end level", env_level, 11'h7E0);
        chk("R5 end phase", env_phase, 1);
    endtask

    task automatic t_decay_sustain();
        @(negedge clk) begin adsr_cfg0 = 8'hFF; adsr_cfg1 = 8'hDF; end
        kon();
        ticks(32);
        chk("R6 decay level", env_level, 11'h707);
        chk("R6 decay phase", env_phase, 1);
        ticks(1);
        chk("R6 band level", env_level, 11'h6FF);
        chk("R6 to sustain", env_phase, 2);
        ticks(1);
        chk("R7 step", env_level, 11'h6F8);
        @(negedge clk) adsr_cfg1 = 8'hC0;
        ticks(3);
        chk("R7 rate0 level", env_level, 11'h6F8);
        chk("R7 stays", env_phase, 2);
    endtask

    task automatic t_release();
        kof();
        chk("R3 phase", env_phase, 3);
        ticks(1);
        chk("R3 minus8", env_level, 11'h6F0);
        load_direct(7'h01);
        kof();
        ticks(1);
        chk("R3 direct release", env_level, 11'h008);
        ticks(2);
        chk("R3 floor", env_level, 0);
        @(negedge clk) begin key_on = 1'b1; key_off = 1'b1; end
        @(negedge clk) begin key_on = 1'b0; key_off = 1'b0; end
        chk("R2 phase", env_phase, 0);
        chk("R2 level", env_level, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; key_on = 1'b0; key_off = 1'b0;
        adsr_cfg0 = 8'h00; adsr_cfg1 = 8'h00; gain_cfg = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_lin_up();
        t_period();
        t_lin_dn();
        t_bent();
        t_exp();
        t_attack();
        t_decay_sustain();
        t_release();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule